// File: doc/BRIEF.md
# Delay-Line TDC Timestamp Encoder

This block converts register-captured snapshots of tapped delay lines into hit timestamps. On every clock each channel presents a tap vector, with tap 0 nearest the launch point. When a hit edge has entered the line, the vector shows a boundary between a run of taps that have already switched and a run that has not. The encoder finds that boundary and turns its position into a fine time code. It pairs the fine code with a free-running, wrapping coarse cycle counter to build a timestamp, and tags the timestamp with the polarity of the edge.

A shared mode input selects the dual-transition scheme. In that mode a launcher drives two edges down the same line, and the encoder adds the two boundary positions, which gives about twice as many effective bins. In single-edge mode the one position is doubled, so both modes give codes on the same scale.

A second stage holds the latest timestamp of two chosen channels. It emits their signed interval, coarse difference minus fine difference, each time either of them records a new hit. The fine code measures the time from the hit to the next clock edge, which is why the fine parts are subtracted.

Top module: `tdc_stamp_encoder`

## Requirements
- R1: A vector whose tap 0 is 1 is a rising hit and gives pol=1. A vector whose tap 0 is 0 is a falling hit and gives pol=0. The vector is inverted to a leading-ones form when tap 0 is 0.
- R2: In the leading-ones form, a boundary lies at index p (2 ≤ p ≤ TAPS−2) when taps p−2 and p−1 agree, taps p and p+1 agree, and tap p−1 differs from tap p. A single stray tap inside a run is therefore not a boundary, and a boundary closer than two taps to either end of the line is not detected.
- R3: In single-edge mode (dual_mode=0) a hit needs exactly one boundary p, and the fine code is 2·p.
- R4: In dual mode (dual_mode=1) a hit needs exactly two boundaries p1 < p2, and the fine code is p1+p2.
- R5: A uniform vector (all taps 0 or all taps 1) is idle. It raises neither valid nor error.
- R6: A non-uniform vector raises the channel's error for one cycle and gives no timestamp when any of these holds: the boundary count differs from what the mode expects, or tap 1 of the leading-ones form is 0.
- R7: The valid, error and timestamp outputs follow the input vector by one clock, and valid is a one-cycle pulse. The timestamp holds the coarse counter value of the cycle in which the vector was presented. The coarse counter is CW bits wide, steps every cycle and wraps.
- R8: diff_o = sext((coarse_A − coarse_B) mod 2^CW)·2^FW − (fine_A − fine_B), with FW = clog2(TAPS)+1. diff_valid_o pulses one cycle after a timestamp on channel A or B, but only once both channels have recorded a hit since reset.
- R9: While rst_n is low, all valid and error outputs are 0.
- R10: Channels are independent. An idle vector on one channel gives no valid and no error there, whatever the other channels present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which the tap vectors are sampled |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dual_mode | input | 1 | 1 selects two transitions per line, 0 selects one |
| taps_i | input | NCH·TAPS | Tap vectors, channel c in bits [c·TAPS +: TAPS], tap 0 lowest |
| ts_valid_o | output | NCH | One-cycle timestamp strobe per channel |
| ts_pol_o | output | NCH | Edge polarity per channel, 1 rising, 0 falling |
| ts_coarse_o | output | NCH·CW | Coarse counter value per channel |
| ts_fine_o | output | NCH·FW | Fine code per channel |
| err_o | output | NCH | One-cycle malformed-vector flag per channel |
| diff_valid_o | output | 1 | Interval strobe |
| diff_o | output | CW+FW+1 | Signed interval, channel A minus channel B, in fine units |

## Verification
The bench builds the block with TAPS=16, CW=8 and two channels. A 16-tap line keeps every vector short enough to work out by hand, including boundaries at the first and last detectable index, bubbles and three-boundary patterns. The 8-bit coarse counter wraps every 256 cycles, so the bench can reach a coarse step that only makes sense modulo 2^CW. It can also reach an interval whose coarse part goes negative through sign extension. The interval checks derive the coarse part from the known cycle spacing of the hits, not from the coarse outputs.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_e;

  localparam logic [1:0] BND_SINGLE = 2'd1;
  localparam logic [1:0] BND_DUAL   = 2'd2;

endpackage

// File: rtl/tdc_rst_sync.sv
module tdc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/tdc_edge_finder.sv
module tdc_edge_finder
  import tdc_pkg::*;
#(
  parameter int TAPS = 32,
  parameter int IW   = $clog2(TAPS),
  parameter int FW   = IW + 1
) (
  input  logic [TAPS-1:0] taps_i,
  input  logic            dual_i,
  output logic            hit_o,
  output logic            err_o,
  output logic            pol_o,
  output logic [FW-1:0]   fine_o
);

  logic [TAPS-1:0] norm;
  logic [TAPS-1:0] bnd;
  logic            idle;
  logic [1:0]      cnt;
  logic [1:0]      want;
  logic [IW-1:0]   p1;
  logic [IW-1:0]   p2;
  logic            shape_ok;

  // leading-ones form of the snapshot
  assign norm = taps_i[0] ? taps_i : ~taps_i;
  assign idle = &norm;

  // boundary candidates need two agreeing taps on each side
  for (genvar g = 0; g < TAPS; g++) begin : g_bnd
    if (g >= 2 && g <= TAPS - 2) begin : g_mid
      assign bnd[g] = (norm[g-2] == norm[g-1]) && (norm[g] == norm[g+1]) &&
                      (norm[g-1] != norm[g]);
    end else begin : g_end
      assign bnd[g] = 1'b0;
    end
  end

  always_comb begin
    cnt = 2'd0;
    p1  = '0;
    p2  = '0;
    for (int p = 0; p < TAPS; p++) begin
      if (bnd[p]) begin
        if (cnt == 2'd0)      p1 = IW'(p);
        else if (cnt == 2'd1) p2 = IW'(p);
        if (cnt != 2'd3) cnt = cnt + 2'd1;
      end
    end
  end

  always_comb begin
    want     = dual_i ? BND_DUAL : BND_SINGLE;
    shape_ok = norm[1] && (cnt == want);
    hit_o    = !idle && shape_ok;
    err_o    = !idle && !shape_ok;
    pol_o    = taps_i[0] ? EDGE_RISE : EDGE_FALL;
    fine_o   = dual_i ? ({1'b0, p1} + {1'b0, p2}) : {p1, 1'b0};
  end

endmodule

// File: rtl/tdc_interval.sv
module tdc_interval #(
  parameter int CW = 24,
  parameter int FW = 6,
  parameter int DW = CW + FW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] coarse_a,
  input  logic [CW-1:0] coarse_b,
  input  logic [FW-1:0] fine_a,
  input  logic [FW-1:0] fine_b,
  input  logic          update,
  input  logic          both_seen,
  output logic          diff_valid,
  output logic [DW-1:0] diff
);

  logic [CW-1:0] dc_raw;
  logic [DW-1:0] dc_ext;
  logic [DW-1:0] dc_scaled;
  logic [DW-1:0] df;
  logic [DW-1:0] diff_d;
  logic          valid_d;
  logic          valid_q;
  logic [DW-1:0] diff_q;

  always_comb begin
    dc_raw    = coarse_a - coarse_b;
    dc_ext    = {{(DW-CW){dc_raw[CW-1]}}, dc_raw};
    dc_scaled = dc_ext << FW;
    df        = {{(DW-FW){1'b0}}, fine_a} - {{(DW-FW){1'b0}}, fine_b};
    diff_d    = dc_scaled - df;
    valid_d   = update && both_seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (valid_d) diff_q <= diff_d;
  end

  assign diff_valid = valid_q;
  assign diff       = diff_q;

endmodule

// File: rtl/tdc_stamp_encoder.sv
module tdc_stamp_encoder #(
  parameter int TAPS   = 32,
  parameter int NCH    = 2,
  parameter int CW     = 24,
  parameter int DIFF_A = 0,
  parameter int DIFF_B = 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              dual_mode,
  input  logic [NCH*TAPS-1:0]               taps_i,
  output logic [NCH-1:0]                    ts_valid_o,
  output logic [NCH-1:0]                    ts_pol_o,
  output logic [NCH*CW-1:0]                 ts_coarse_o,
  output logic [NCH*($clog2(TAPS)+1)-1:0]   ts_fine_o,
  output logic [NCH-1:0]                    err_o,
  output logic                              diff_valid_o,
  output logic [CW+$clog2(TAPS)+1:0]        diff_o
);

  localparam int IW = $clog2(TAPS);
  localparam int FW = IW + 1;
  localparam int DW = CW + FW + 1;

  logic          rst_q_n;
  logic [CW-1:0] coarse_q;
  logic [CW-1:0] coarse_d;
  logic [NCH-1:0] have_q;

  tdc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign coarse_d = coarse_q + 1'b1;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) coarse_q <= '0;
    else          coarse_q <= coarse_d;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          hit;
    logic          err;
    logic          pol;
    logic [FW-1:0] fine;
    logic          valid_q;
    logic          err_q;
    logic          pol_q;
    logic [CW-1:0] crs_q;
    logic [FW-1:0] fine_q;

    tdc_edge_finder #(.TAPS(TAPS), .IW(IW), .FW(FW)) u_find (
      .taps_i (taps_i[c*TAPS +: TAPS]),
      .dual_i (dual_mode),
      .hit_o  (hit),
      .err_o  (err),
      .pol_o  (pol),
      .fine_o (fine)
    );

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) begin
        valid_q   <= 1'b0;
        err_q     <= 1'b0;
        have_q[c] <= 1'b0;
      end else begin
        valid_q <= hit;
        err_q   <= err;
        if (hit) have_q[c] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (hit) begin
        crs_q  <= coarse_q;
        fine_q <= fine;
        pol_q  <= pol;
      end
    end

    assign ts_valid_o[c]            = valid_q;
    assign err_o[c]                 = err_q;
    assign ts_pol_o[c]              = pol_q;
    assign ts_coarse_o[c*CW +: CW]  = crs_q;
    assign ts_fine_o[c*FW +: FW]    = fine_q;
  end

  tdc_interval #(.CW(CW), .FW(FW), .DW(DW)) u_diff (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .coarse_a   (ts_coarse_o[DIFF_A*CW +: CW]),
    .coarse_b   (ts_coarse_o[DIFF_B*CW +: CW]),
    .fine_a     (ts_fine_o[DIFF_A*FW +: FW]),
    .fine_b     (ts_fine_o[DIFF_B*FW +: FW]),
    .update     (ts_valid_o[DIFF_A] | ts_valid_o[DIFF_B]),
    .both_seen  (have_q[DIFF_A] & have_q[DIFF_B]),
    .diff_valid (diff_valid_o),
    .diff       (diff_o)
  );

endmodule

// File: rtl/tdc_stamp_checker.sv
module tdc_stamp_checker #(
  parameter int TAPS   = 32,
  parameter int NCH    = 2,
  parameter int CW     = 24,
  parameter int DIFF_A = 0,
  parameter int DIFF_B = 1
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            dual_mode,
  input logic [NCH-1:0]                  ts_valid_o,
  input logic [NCH*CW-1:0]               ts_coarse_o,
  input logic [NCH*($clog2(TAPS)+1)-1:0] ts_fine_o,
  input logic [NCH-1:0]                  err_o,
  input logic                            diff_valid_o
);

  localparam int FW = $clog2(TAPS) + 1;

  // reset keeps every strobe low
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R9: assert (ts_valid_o == '0 && err_o == '0 && !diff_valid_o);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_valid_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ts_valid_o[c] && err_o[c]));

    assert_coarse_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ts_valid_o[c] && $past(ts_valid_o[c])) |->
      (ts_coarse_o[c*CW +: CW] == CW'($past(ts_coarse_o[c*CW +: CW]) + 1'b1)));

    assert_single_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ts_valid_o[c] |-> ($past(dual_mode) || !ts_fine_o[c*FW]));

    assert_fine_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ts_valid_o[c] |-> (ts_fine_o[c*FW +: FW] >= FW'(4) &&
                         ts_fine_o[c*FW +: FW] <= FW'(2*TAPS-4)));
  end

  assert_diff_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    diff_valid_o |-> $past(ts_valid_o[DIFF_A] || ts_valid_o[DIFF_B]));

endmodule

bind tdc_stamp_encoder tdc_stamp_checker #(
  .TAPS(TAPS), .NCH(NCH), .CW(CW), .DIFF_A(DIFF_A), .DIFF_B(DIFF_B)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dual_mode    (dual_mode),
  .ts_valid_o   (ts_valid_o),
  .ts_coarse_o  (ts_coarse_o),
  .ts_fine_o    (ts_fine_o),
  .err_o        (err_o),
  .diff_valid_o (diff_valid_o)
);

// File: tb/tb_tdc_stamp_encoder.sv
module tb_tdc_stamp_encoder;

  localparam int TAPS = 16;
  localparam int NCH  = 2;
  localparam int CW   = 8;
  localparam int FW   = 5;
  localparam int DW   = CW + FW + 1;
  localparam int NROW = 17;

  logic                clk;
  logic                rst_n;
  logic                dual_mode;
  logic [TAPS-1:0]     taps0, taps1;
  logic [NCH-1:0]      ts_valid, ts_pol, err;
  logic [NCH*CW-1:0]   ts_coarse;
  logic [NCH*FW-1:0]   ts_fine;
  logic                diff_valid;
  logic [DW-1:0]       diff;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  tdc_stamp_encoder #(.TAPS(TAPS), .NCH(NCH), .CW(CW), .DIFF_A(0), .DIFF_B(1)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .dual_mode    (dual_mode),
    .taps_i       ({taps1, taps0}),
    .ts_valid_o   (ts_valid),
    .ts_pol_o     (ts_pol),
    .ts_coarse_o  (ts_coarse),
    .ts_fine_o    (ts_fine),
    .err_o        (err),
    .diff_valid_o (diff_valid),
    .diff_o       (diff)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // row: {dual, taps, valid, err, pol, fine, req}
  localparam logic [28:0] ROWS [NROW] = '{
    {1'b0, 16'h003F, 1'b1, 1'b0, 1'b1, 5'd12, 4'd3},  // R3 rising, p=6
    {1'b0, 16'hFF00, 1'b1, 1'b0, 1'b0, 5'd16, 4'd1},  // R1 falling, p=8
    {1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 5'd0,  4'd5},  // R5 idle low
    {1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 5'd0,  4'd5},  // R5 idle high
    {1'b0, 16'h00F7, 1'b1, 1'b0, 1'b1, 5'd16, 4'd2},  // R2 bubble at tap 3
    {1'b0, 16'h0F0F, 1'b0, 1'b1, 1'b0, 5'd0,  4'd6},  // R6 three boundaries
    {1'b1, 16'hFC07, 1'b1, 1'b0, 1'b1, 5'd13, 4'd4},  // R4 p=3,10
    {1'b1, 16'h03F8, 1'b1, 1'b0, 1'b0, 5'd13, 4'd4},  // R4 falling pair
    {1'b0, 16'hFC07, 1'b0, 1'b1, 1'b0, 5'd0,  4'd6},  // R6 two in single
    {1'b1, 16'h003F, 1'b0, 1'b1, 1'b0, 5'd0,  4'd6},  // R6 one in dual
    {1'b0, 16'h0001, 1'b0, 1'b1, 1'b0, 5'd0,  4'd6},  // R6 short lead run
    {1'b0, 16'hFFFE, 1'b0, 1'b1, 1'b0, 5'd0,  4'd6},  // R6 short lead, falling
    {1'b0, 16'h7FFF, 1'b0, 1'b1, 1'b0, 5'd0,  4'd2},  // R2 boundary past end
    {1'b0, 16'h3FFF, 1'b1, 1'b0, 1'b1, 5'd28, 4'd2},  // R2 last index 14
    {1'b0, 16'h0003, 1'b1, 1'b0, 1'b1, 5'd4,  4'd2},  // R2 first index 2
    {1'b1, 16'hC003, 1'b1, 1'b0, 1'b1, 5'd16, 4'd4},  // R4 p=2,14
    {1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b0, 5'd0,  4'd5}   // R5 idle in dual
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [TAPS-1:0] t0, input logic [TAPS-1:0] t1, input logic d);
    @(negedge clk);
    taps0     = t0;
    taps1     = t1;
    dual_mode = d;
    @(posedge clk);
    #1;
  endtask

  function automatic int exp_diff(input int spacing_a_minus_b, input int fa, input int fb);
    int dc;
    dc = spacing_a_minus_b % 256;
    if (dc < 0)    dc += 256;
    if (dc >= 128) dc -= 256;
    return dc * 32 - (fa - fb);
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [28:0] r;
    int c1, c2;
    rst_n = 1'b0; dual_mode = 1'b0; taps0 = '0; taps1 = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(ts_valid == '0, "R9", "ts_valid in reset", int'(ts_valid), 0);
    chk(err == '0, "R9", "err in reset", int'(err), 0);
    chk(!diff_valid, "R9", "diff_valid in reset", int'(diff_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) drive('0, '0, 1'b0);

    for (int i = 0; i < NROW; i++) begin
      r = ROWS[i];
      drive(r[27:12], 16'h0000, r[28]);
      chk(ts_valid[0] == r[11], $sformatf("R%0d", r[3:0]), $sformatf("row %0d valid", i),
          int'(ts_valid[0]), int'(r[11]));
      chk(err[0] == r[10], $sformatf("R%0d", r[3:0]), $sformatf("row %0d err", i),
          int'(err[0]), int'(r[10]));
      chk(ts_valid[1] == 1'b0 && err[1] == 1'b0, "R10", $sformatf("row %0d idle channel", i),
          int'({ts_valid[1], err[1]}), 0);
      if (r[11]) begin
        chk(ts_pol[0] == r[9], "R1", $sformatf("row %0d polarity", i),
            int'(ts_pol[0]), int'(r[9]));
        chk(ts_fine[4:0] == r[8:4], $sformatf("R%0d", r[3:0]), $sformatf("row %0d fine", i),
            int'(ts_fine[4:0]), int'(r[8:4]));
        drive('0, '0, r[28]);
        chk(ts_valid[0] == 1'b0, "R7", $sformatf("row %0d valid pulse width", i),
            int'(ts_valid[0]), 0);
      end
    end

    // coarse step between hits ten cycles apart
    drive(16'h003F, '0, 1'b0);
    c1 = int'(ts_coarse[7:0]);
    repeat (9) drive('0, '0, 1'b0);
    drive(16'h003F, '0, 1'b0);
    c2 = int'(ts_coarse[7:0]);
    chk(((c2 - c1) & 255) == 10, "R7", "coarse step 10", (c2 - c1) & 255, 10);
    chk(!diff_valid, "R8", "no interval before channel 1 hit", int'(diff_valid), 0);

    // coarse wrap: 300 cycles apart
    c1 = c2;
    repeat (299) drive('0, '0, 1'b0);
    drive(16'h003F, '0, 1'b0);
    c2 = int'(ts_coarse[7:0]);
    chk(((c2 - c1) & 255) == 44, "R7", "coarse wrap 300", (c2 - c1) & 255, 44);
    drive('0, '0, 1'b0);
    chk(!diff_valid, "R8", "still no interval", int'(diff_valid), 0);

    // simultaneous hits: fine 12 vs 4
    drive(16'h003F, 16'h0003, 1'b0);
    chk(!diff_valid, "R8", "interval one cycle late", int'(diff_valid), 0);
    drive('0, '0, 1'b0);
    chk(diff_valid, "R8", "interval strobe same cycle", int'(diff_valid), 1);
    chk($signed(diff) == exp_diff(0, 12, 4), "R8", "interval same cycle",
        int'($signed(diff)), exp_diff(0, 12, 4));
    drive('0, '0, 1'b0);
    chk(!diff_valid, "R8", "interval strobe one cycle", int'(diff_valid), 0);

    // channel 1 five cycles after channel 0: fine 12 vs 16
    drive(16'h003F, '0, 1'b0);
    repeat (4) drive('0, '0, 1'b0);
    drive('0, 16'hFF00, 1'b0);
    drive('0, '0, 1'b0);
    chk(diff_valid, "R8", "interval strobe spacing 5", int'(diff_valid), 1);
    chk($signed(diff) == exp_diff(-5, 12, 16), "R8", "interval spacing 5",
        int'($signed(diff)), exp_diff(-5, 12, 16));

    // channel 0 two hundred cycles after channel 1: wraps to negative
    drive('0, 16'h0003, 1'b0);
    repeat (199) drive('0, '0, 1'b0);
    drive(16'h003F, '0, 1'b0);
    drive('0, '0, 1'b0);
    chk(diff_valid, "R8", "interval strobe spacing 200", int'(diff_valid), 1);
    chk($signed(diff) == exp_diff(200, 12, 4), "R8", "interval spacing 200 wrapped",
        int'($signed(diff)), exp_diff(200, 12, 4));

    // channel 1 dual hit while channel 0 idle
    drive('0, 16'hFC07, 1'b1);
    chk(ts_valid == 2'b10, "R10", "only channel 1 valid", int'(ts_valid), 2);
    chk(ts_fine[9:5] == 5'd13, "R4", "channel 1 dual fine", int'(ts_fine[9:5]), 13);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule